// File: doc/BRIEF.md
# Local bus packet transfer controller

This block moves one packet between an on-chip word FIFO and a target on an external local bus. Software loads a packet length, a starting bus address, a chip select and a direction. It then sets a go flag, which may be written some time after the rest of the setup. A sequencer issues one 32-bit bus cycle per word over a request/acknowledge handshake and advances the bus address by four after each word. It counts the bytes moved and, at the end, raises a completion flag. If the bus signals an error, it raises an abort flag instead.

The FIFO is much smaller than the largest packet. Software or a DMA engine therefore keeps it topped up while a bus-write packet runs, and drains it while a bus-read packet runs. The sequencer waits whenever the FIFO cannot supply or accept a word. A programmable watermark drives a DMA request line. One interrupt line combines the two end flags, each under its own mask, and the master enable gates the result. Two hold-in-reset bits clear the engine and the FIFO separately.

Top module: `lbf_xfer_ctrl`

## Requirements
- R1: After reset, the status word at offset 0x14 reads 0, the FIFO status word at offset 0x44 reads 1 (bit 0 = empty, level 0), and irq, dma_req and lb_req are all low.
- R2: Writing byte lane 3 of offset 0x00 with value 0x01 sets a pending go flag, read back in bit 24 of offset 0x00. The transfer starts only when the master enable (offset 0x0C bit 0) is set and no reset bit is held. The go flag clears when the transfer starts. Until then no bus cycle occurs.
- R3: In bus-write mode (offset 0x08 bit 16 = 0), each word is taken from the FIFO in order and driven on lb_wdata with lb_we high and lb_cs equal to offset 0x08 bits 31:24. The bus address is the start address (offset 0x04) plus 4 per word. lb_req stays high until lb_ack. No bus cycle is issued while the FIFO is empty.
- R4: In bus-read mode (offset 0x08 bit 16 = 1), each acknowledged lb_rdata word is pushed into the FIFO, and reads of offset 0x40 return the words in bus order. No bus cycle is issued while the FIFO is full (offset 0x44 bit 1).
- R5: A packet of N bytes uses ceil(N/4) bus cycles. On completion, offset 0x14 bits 23:0 read N and bit 24 (complete) is set.
- R6: Writing 1 to bit 24 of offset 0x14 with byte lane 3 enabled clears the completion flag.
- R7: An lb_err returned with lb_ack sets the abort flag (offset 0x14 bit 28) and stops the packet. The byte count covers only the words acknowledged without error.
- R8: irq is high one cycle after master enable AND ((complete AND offset 0x0C bit 8) OR (abort AND offset 0x0C bit 9)) is true, and low one cycle after it is false.
- R9: While offset 0x0C bit 24 is set, the sequencer, byte count, status flags and go flag are cleared. While bit 16 is set, the FIFO is emptied.
- R10: dma_req is high while master enable is set and neither end flag is set. In bus-write mode the FIFO level in bytes (offset 0x44 bits 31:16) must also be below the alarm (offset 0x4C). In bus-read mode the level plus the alarm must be at least the FIFO size in bytes. Offset 0x48 bits 2:0 hold a request granularity for the DMA engine.
- R11: A packet of length 0 completes with no bus cycle and a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte lane enables for writes |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| lb_req | output | 1 | Bus cycle request, held until acknowledge |
| lb_we | output | 1 | Bus cycle is a write |
| lb_cs | output | 8 | Chip select number |
| lb_addr | output | ADDR_W | Bus byte address |
| lb_wdata | output | 32 | Bus write data |
| lb_rdata | input | 32 | Bus read data, valid with lb_ack |
| lb_ack | input | 1 | Bus cycle acknowledge |
| lb_err | input | 1 | Bus error, valid with lb_ack |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Watermark-driven DMA request |

## Verification
The bench builds the block with FIFO_BYTES = 16, which gives a four-word FIFO. A 24-byte read packet can then overrun the FIFO, so the bench can observe the full-FIFO stall and the refill driven by software pops. The small size also puts both watermark settings close to the empty and full points, so dma_req changes within a handful of pushes. The default 24-bit length and 32-bit address are kept, so the byte counter and address stepping run at their real widths.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_BUS} sq_state_t;

  localparam logic [7:0] OFS_LEN   = 8'h00;
  localparam logic [7:0] OFS_ADDR  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_EN    = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h14;
  localparam logic [7:0] OFS_FDATA = 8'h40;
  localparam logic [7:0] OFS_FSTAT = 8'h44;
  localparam logic [7:0] OFS_FCTL  = 8'h48;
  localparam logic [7:0] OFS_ALARM = 8'h4C;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/lbf_fifo.sv
module lbf_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] q,
  output logic [PW:0]   count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr, nxt_r;
  logic          do_push, do_pop;

  assign full    = (count == (PW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign nxt_r   = do_pop ? rptr + PW'(1) : rptr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  // head word register: shows mem[rptr], bypassing a write into that slot
  always_ff @(posedge clk) begin
    if (do_push && (wptr == nxt_r)) q <= wdata;
    else                            q <= mem[nxt_r];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + PW'(1);
      rptr <= nxt_r;
      case ({do_push, do_pop})
        2'b10:   count <= count + (PW+1)'(1);
        2'b01:   count <= count - (PW+1)'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lbf_seq.sv
module lbf_seq
  import lbf_pkg::*;
#(
  parameter int SIZE_W = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        cs_i,
  input  logic              f_empty,
  input  logic              f_full,
  input  logic [31:0]       f_q,
  output logic              f_pop,
  output logic              f_push,
  input  logic              lb_ack,
  input  logic              lb_err,
  output logic              lb_req,
  output logic              lb_we,
  output logic [ADDR_W-1:0] lb_addr,
  output logic [7:0]        lb_cs,
  output logic [31:0]       lb_wdata,
  output logic              busy,
  output logic              rd_mode,
  output logic [SIZE_W-1:0] done_cnt,
  output logic              cmpl_p,
  output logic              abort_p
);
  sq_state_t         state;
  logic [SIZE_W-1:0] size_q, rem, step;

  assign rem      = size_q - done_cnt;
  assign step     = (rem >= SIZE_W'(4)) ? SIZE_W'(4) : rem;
  assign busy     = (state != SQ_IDLE);
  assign lb_req   = (state == SQ_BUS);
  assign lb_we    = ~rd_mode;
  assign f_pop    = (state == SQ_RUN) && (rem != '0) && !rd_mode && !f_empty;
  assign f_push   = (state == SQ_BUS) && lb_ack && !lb_err && rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      size_q   <= '0;
      done_cnt <= '0;
      lb_addr  <= '0;
      lb_cs    <= '0;
      lb_wdata <= '0;
      rd_mode  <= 1'b0;
      cmpl_p   <= 1'b0;
      abort_p  <= 1'b0;
    end else begin
      cmpl_p  <= 1'b0;
      abort_p <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          size_q   <= size_i;
          lb_addr  <= addr_i;
          lb_cs    <= cs_i;
          rd_mode  <= rd_i;
          done_cnt <= '0;
          state    <= SQ_RUN;
        end
        SQ_RUN: begin
          if (rem == '0) begin
            cmpl_p <= 1'b1;
            state  <= SQ_IDLE;
          end else if (!rd_mode && !f_empty) begin
            lb_wdata <= f_q;
            state    <= SQ_BUS;
          end else if (rd_mode && !f_full) begin
            state <= SQ_BUS;
          end
        end
        SQ_BUS: if (lb_ack) begin
          if (lb_err) begin
            abort_p <= 1'b1;
            state   <= SQ_IDLE;
          end else begin
            done_cnt <= done_cnt + step;
            lb_addr  <= lb_addr + ADDR_W'(4);
            state    <= SQ_RUN;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbf_xfer_ctrl.sv
module lbf_xfer_ctrl
  import lbf_pkg::*;
#(
  parameter int FIFO_BYTES = 512,
  parameter int SIZE_W     = 24,
  parameter int ADDR_W     = 32,
  localparam int DEPTH     = FIFO_BYTES / 4,
  localparam int PW        = $clog2(DEPTH),
  localparam int LW        = PW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  output logic              lb_req,
  output logic              lb_we,
  output logic [7:0]        lb_cs,
  output logic [ADDR_W-1:0] lb_addr,
  output logic [31:0]       lb_wdata,
  input  logic [31:0]       lb_rdata,
  input  logic              lb_ack,
  input  logic              lb_err,
  output logic              irq,
  output logic              dma_req
);
  localparam logic [LW:0] FB_L = (LW+1)'(FIFO_BYTES);

  logic [SIZE_W-1:0] len_q;
  logic              go_q, cmpl_q, abort_q;
  logic [31:0]       addr_img, ctrl_img, en_img, fctl_img, alarm_img;
  logic              eng_rst, fifo_rst, master_en, start;
  logic              seq_busy, seq_rd, seq_pop, seq_push, seq_cmpl, seq_abort;
  logic [SIZE_W-1:0] done_cnt;
  logic              f_full, f_empty, f_push, f_pop, cpu_push, cpu_pop;
  logic [31:0]       f_q, f_wdata;
  logic [PW:0]       f_count;
  logic [LW-1:0]     lvl;
  logic              dma_cond;

  assign eng_rst   = en_img[24];
  assign fifo_rst  = en_img[16];
  assign master_en = en_img[0];
  assign start     = go_q & master_en & ~eng_rst & ~seq_busy;

  assign cpu_push = reg_wr && (reg_addr == OFS_FDATA);
  assign cpu_pop  = reg_rd && (reg_addr == OFS_FDATA) && !f_empty;
  assign f_push   = seq_push | cpu_push;
  assign f_wdata  = seq_push ? lb_rdata : reg_wdata;
  assign f_pop    = seq_pop | cpu_pop;
  assign lvl      = {f_count, 2'b00};

  lbf_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
    .clk(clk), .clr(rst | fifo_rst), .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .q(f_q), .count(f_count), .full(f_full), .empty(f_empty)
  );

  lbf_seq #(.SIZE_W(SIZE_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst | eng_rst), .start(start), .rd_i(ctrl_img[16]),
    .size_i(len_q), .addr_i(addr_img[ADDR_W-1:0]), .cs_i(ctrl_img[31:24]),
    .f_empty(f_empty), .f_full(f_full), .f_q(f_q), .f_pop(seq_pop),
    .f_push(seq_push), .lb_ack(lb_ack), .lb_err(lb_err), .lb_req(lb_req),
    .lb_we(lb_we), .lb_addr(lb_addr), .lb_cs(lb_cs), .lb_wdata(lb_wdata),
    .busy(seq_busy), .rd_mode(seq_rd), .done_cnt(done_cnt),
    .cmpl_p(seq_cmpl), .abort_p(seq_abort)
  );

  // register file writes
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      go_q      <= 1'b0;
      addr_img  <= '0;
      ctrl_img  <= '0;
      en_img    <= '0;
      fctl_img  <= '0;
      alarm_img <= '0;
    end else begin
      if (start || eng_rst) go_q <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          OFS_LEN: begin
            len_q <= SIZE_W'(lane_merge(32'(len_q), reg_wdata, {1'b0, reg_be[2:0]}));
            if (reg_be[3] && reg_wdata[31:24] == 8'h01) go_q <= 1'b1;
          end
          OFS_ADDR:  addr_img  <= lane_merge(addr_img, reg_wdata, reg_be);
          OFS_CTRL:  ctrl_img  <= lane_merge(ctrl_img, reg_wdata, reg_be);
          OFS_EN:    en_img    <= lane_merge(en_img, reg_wdata, reg_be);
          OFS_FCTL:  fctl_img  <= lane_merge(fctl_img, reg_wdata, reg_be);
          OFS_ALARM: alarm_img <= lane_merge(alarm_img, reg_wdata, reg_be);
          default: ;
        endcase
      end
    end
  end

  // end-of-packet flags
  always_ff @(posedge clk) begin
    if (rst || eng_rst || start) begin
      cmpl_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (seq_cmpl) cmpl_q <= 1'b1;
      else if (reg_wr && reg_addr == OFS_STAT && reg_be[3] && reg_wdata[24])
        cmpl_q <= 1'b0;
      if (seq_abort) abort_q <= 1'b1;
    end
  end

  assign dma_cond = ctrl_img[16]
                  ? (({1'b0, lvl} + {1'b0, alarm_img[LW-1:0]}) >= FB_L)
                  : (lvl < alarm_img[LW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      dma_req   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq     <= master_en & ((cmpl_q & en_img[8]) | (abort_q & en_img[9]));
      dma_req <= master_en & ~eng_rst & ~cmpl_q & ~abort_q & dma_cond;
      if (reg_rd) begin
        case (reg_addr)
          OFS_LEN:   reg_rdata <= {7'b0, go_q, 24'(len_q)};
          OFS_ADDR:  reg_rdata <= addr_img;
          OFS_CTRL:  reg_rdata <= ctrl_img;
          OFS_EN:    reg_rdata <= en_img;
          OFS_STAT:  reg_rdata <= {3'b0, abort_q, 3'b0, cmpl_q, 24'(done_cnt)};
          OFS_FDATA: reg_rdata <= f_q;
          OFS_FSTAT: reg_rdata <= {16'(lvl), 14'b0, f_full, f_empty};
          OFS_FCTL:  reg_rdata <= fctl_img;
          OFS_ALARM: reg_rdata <= alarm_img;
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lbf_chk.sv
module lbf_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              lb_req,
  input logic              lb_ack,
  input logic              lb_err,
  input logic [ADDR_W-1:0] lb_addr,
  input logic              seq_rd,
  input logic              f_full,
  input logic              f_empty,
  input logic              abort_q,
  input logic              eng_rst
);
  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_req && !lb_ack && !eng_rst) |=> lb_req);

  // R3
  no_write_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(lb_req) && !seq_rd) |-> !$past(f_empty));

  // R4
  no_read_on_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(lb_req) && seq_rd) |-> !$past(f_full));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lb_req && lb_ack && !lb_err && !eng_rst) |=> (lb_addr == $past(lb_addr) + ADDR_W'(4)));

  // R7
  abort_stops_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_q) |-> !lb_req);

  // R9
  eng_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst |=> !lb_req);
endmodule

bind lbf_xfer_ctrl lbf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .lb_req(lb_req), .lb_ack(lb_ack), .lb_err(lb_err),
  .lb_addr(lb_addr), .seq_rd(seq_rd), .f_full(f_full), .f_empty(f_empty),
  .abort_q(abort_q), .eng_rst(eng_rst)
);

// File: tb/test_lbf_xfer_ctrl.sv
module test_lbf_xfer_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        lb_req, lb_we;
  logic [7:0]  lb_cs;
  logic [31:0] lb_addr, lb_wdata;
  logic [31:0] lb_rdata = '0;
  logic        lb_ack = 1'b0, lb_err = 1'b0;
  logic        irq, dma_req;

  int n_chk = 0, n_fail = 0, n_bus = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [7:0]  exp_cs = 8'd3;
  logic [63:0] exp_wr [$];
  logic [31:0] exp_rd [$];

  always #4 clk = ~clk;

  lbf_xfer_ctrl #(.FIFO_BYTES(16)) i_lbf_xfer_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .lb_req(lb_req), .lb_we(lb_we), .lb_cs(lb_cs), .lb_addr(lb_addr),
    .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .lb_ack(lb_ack), .lb_err(lb_err),
    .irq(irq), .dma_req(dma_req)
  );

  function automatic logic [31:0] model_rd(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus target model and scoreboard for bus cycles
  initial begin
    forever begin
      @(negedge clk);
      if (lb_req && !lb_ack) begin
        lb_ack   = 1'b1;
        lb_err   = (lb_addr == err_addr);
        lb_rdata = model_rd(lb_addr);
        n_bus++;
        chk("R3 chip select", 32'(lb_cs), 32'(exp_cs));
        if (lb_we) begin
          if (exp_wr.size() == 0) chk("R3 unexpected bus write", lb_addr, 32'hDEAD_DEAD);
          else begin
            logic [63:0] e;
            e = exp_wr.pop_front();
            chk("R3 write address", lb_addr, e[63:32]);
            chk("R3 write data", lb_wdata, e[31:0]);
          end
        end else if (!lb_err) begin
          exp_rd.push_back(model_rd(lb_addr));
        end
      end else begin
        lb_ack = 1'b0;
        lb_err = 1'b0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push_word(input logic [31:0] a, input logic [31:0] d);
    exp_wr.push_back({a, d});
    wr(8'h40, d, 4'hF);
  endtask

  task automatic pop_check(input string tag);
    logic [31:0] s, d;
    for (int i = 0; i < 100; i++) begin
      rd(8'h44, s);
      if (!s[0]) break;
    end
    rd(8'h40, d);
    if (exp_rd.size() == 0) chk({tag, " no expected word"}, d, 32'hDEAD_DEAD);
    else chk(tag, d, exp_rd.pop_front());
  endtask

  task automatic wait_end(output logic [31:0] s);
    for (int i = 0; i < 300; i++) begin
      rd(8'h14, s);
      if (s[24] || s[28]) break;
    end
  endtask

  task automatic go(input logic [31:0] a, input logic [23:0] len, input logic rdm);
    wr(8'h04, a, 4'hF);
    wr(8'h08, {exp_cs, 7'b0, rdm, 12'b0, 1'b1, 3'b0}, 4'hF);
    wr(8'h00, {8'h00, len}, 4'h7);
    wr(8'h00, 32'h0100_0000, 4'h8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int nb;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h14, s); chk("R1 status after reset", s, 32'h0);
    rd(8'h44, s); chk("R1 fifo status after reset", s, 32'h1);
    chk("R1 irq/dma/req after reset", {29'b0, irq, dma_req, lb_req}, 32'h0);

    // R10 write-mode watermark
    wr(8'h0C, 32'h0000_0301, 4'hF);
    wr(8'h4C, 32'd12, 4'hF);
    wr(8'h48, 32'd7, 4'hF);
    wr(8'h08, {exp_cs, 7'b0, 1'b0, 12'b0, 1'b1, 3'b0}, 4'hF);
    @(negedge clk);
    chk("R10 dma_req with empty fifo, write mode", 32'(dma_req), 32'h1);
    push_word(32'h100, 32'hA000_0001);
    push_word(32'h104, 32'hA000_0002);
    push_word(32'h108, 32'hA000_0003);
    @(negedge clk);
    chk("R10 dma_req off at alarm level", 32'(dma_req), 32'h0);
    rd(8'h44, s); chk("R10 fifo level bytes", s, 32'h000C_0000);

    // R2 deferred go: setup without go does nothing
    nb = n_bus;
    wr(8'h04, 32'h100, 4'hF);
    wr(8'h00, 32'd12, 4'h7);
    repeat (10) @(negedge clk);
    chk("R2 no bus cycle before go", 32'(n_bus - nb), 32'h0);
    wr(8'h00, 32'h0100_0000, 4'h8);
    wait_end(s);
    chk("R5 write packet done, 12 bytes", s, 32'h0100_000C);
    chk("R3 all expected words written", 32'(exp_wr.size()), 32'h0);
    @(negedge clk);
    chk("R8 irq on completion", 32'(irq), 32'h1);
    rd(8'h00, s); chk("R2 go flag cleared after start", 32'(s[24]), 32'h0);

    // R6 clear completion
    wr(8'h14, 32'h0100_0000, 4'h8);
    rd(8'h14, s); chk("R6 completion cleared", s, 32'h0000_000C);
    @(negedge clk);
    chk("R8 irq drops after clear", 32'(irq), 32'h0);

    // R4 read packet larger than the fifo
    wr(8'h4C, 32'd15, 4'hF);
    wr(8'h48, 32'd0, 4'hF);
    go(32'h200, 24'd24, 1'b1);
    repeat (30) @(negedge clk);
    rd(8'h44, s); chk("R4 fifo full during read stall", s, 32'h0010_0002);
    chk("R4 no bus request while full", 32'(lb_req), 32'h0);
    chk("R10 dma_req in read mode with data", 32'(dma_req), 32'h1);
    rd(8'h14, s); chk("R4 not complete while stalled", s, 32'h0000_0010);
    for (int i = 0; i < 6; i++) pop_check("R4 read data order");
    wait_end(s);
    chk("R5 read packet done, 24 bytes", s, 32'h0100_0018);

    // R5 partial final word
    push_word(32'h400, 32'hB000_0001);
    push_word(32'h404, 32'hB000_0002);
    nb = n_bus;
    go(32'h400, 24'd6, 1'b0);
    wait_end(s);
    chk("R5 six-byte packet count", s, 32'h0100_0006);
    chk("R5 two bus cycles for six bytes", 32'(n_bus - nb), 32'h2);

    // R3 stall on empty fifo
    nb = n_bus;
    go(32'h500, 24'd8, 1'b0);
    repeat (20) @(negedge clk);
    rd(8'h14, s); chk("R3 stalled on empty fifo", s, 32'h0);
    chk("R3 no bus cycle while empty", 32'(n_bus - nb), 32'h0);
    push_word(32'h500, 32'hC000_0001);
    push_word(32'h504, 32'hC000_0002);
    wait_end(s);
    chk("R3 completes after refill", s, 32'h0100_0008);

    // R7 bus error aborts
    err_addr = 32'h308;
    go(32'h300, 24'd16, 1'b1);
    wait_end(s);
    chk("R7 abort flag and partial count", s, 32'h1000_0008);
    @(negedge clk);
    chk("R8 irq on abort", 32'(irq), 32'h1);
    pop_check("R7 word before error");
    pop_check("R7 word before error");
    err_addr = 32'hFFFF_FFFF;

    // R9 reset bits
    wr(8'h40, 32'h1234_5678, 4'hF);
    wr(8'h0C, 32'h0101_0301, 4'hF);
    wr(8'h0C, 32'h0000_0301, 4'hF);
    rd(8'h14, s); chk("R9 status cleared by engine reset", s, 32'h0);
    rd(8'h44, s); chk("R9 fifo emptied by fifo reset", s, 32'h1);
    chk("R9 irq low after reset", 32'(irq), 32'h0);

    // R2 master enable gate, R11 zero length
    wr(8'h0C, 32'h0000_0300, 4'hF);
    nb = n_bus;
    go(32'h600, 24'd0, 1'b0);
    repeat (10) @(negedge clk);
    rd(8'h00, s); chk("R2 go stays pending without master enable", 32'(s[24]), 32'h1);
    rd(8'h14, s); chk("R2 no start without master enable", s, 32'h0);
    wr(8'h0C, 32'h0000_0301, 4'hF);
    wait_end(s);
    chk("R11 zero-length packet completes", s, 32'h0100_0000);
    chk("R11 no bus cycle for zero length", 32'(n_bus - nb), 32'h0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule